// File: doc/BRIEF.md
# Rectangle Blit Address Walker

The block is the front end of a 2D block-transfer engine. Software programs a small set of 32-bit parameter words: pixel depth, destination and source positions, rectangle extent, base addresses and row pitches. It then writes a command word. An accepted command starts a walk over the destination rectangle, one pixel per clock, x varying fastest. Each pixel produces a byte address and a valid strobe. For copy operations a matching source address is produced in the same cycle.

Three operations exist. A solid fill touches only the destination. A color copy reads a source of the same depth. A monochrome expansion reads one bit per pixel, so its source address is a byte address plus a bit index. Each axis can be walked backwards under a command bit, so that overlapping copies can be ordered safely. The parameters of a job are captured when the command is accepted. A busy flag and a sticky error flag can be read back through the register port.

Top module: `rect_blit_walker`

## Requirements
- R1: The extent word (word offset 4) holds width minus one in bits 11:0 and height minus one in bits 27:16. An accepted command yields exactly width times height cycles with `pix_valid_o` high, back to back, and a field value of 0 gives a 1-pixel extent.
- R2: The position words at offsets 2 (destination) and 3 (source) hold x in bits 15:0 and y in bits 31:16. The base words at offsets 5 (destination) and 6 (source) hold the byte address divided by 8 in bits 28:0. The pitch word at offset 7 holds the source pitch divided by 8 in bits 10:0 and the destination pitch divided by 8 in bits 26:16. With x stepping inside y, each destination pixel address is base*8 + y*pitch*8 + x*bytes-per-pixel.
- R3: The pixel depth field is bits 9:8 of the mode word (offset 1): code 0 gives 1 byte per pixel, code 1 gives 2 bytes and code 3 gives 4 bytes.
- R4: Command bit 15 walks x from right to left. The x start then names the far edge, and x decreases by one per pixel and returns to the start at each new row.
- R5: Command bit 14 walks y from bottom to top, with the y start naming the far edge and y decreasing by one per row.
- R6: Command bit 13 selects a fill, and `src_valid_o` stays low throughout. Without bit 13 and without bit 1, the operation is a color copy: `src_valid_o` follows `pix_valid_o`, and the source address is formed like the destination address from the source fields, using the same direction bits and depth.
- R7: Command bit 1 without bit 13 selects a monochrome source. The source address is base*8 + y*pitch*8 + (x divided by 8), and `src_bit_o` carries x modulo 8. Source x may use all 15 low bits.
- R8: Writing the command word (offset 0) starts the job. Busy is high from the clock edge that takes the write until the last pixel strobe, and a read of offset 0 returns busy in bit 0 and the error flag in bit 1.
- R9: A command write made while busy is ignored. The running job's address sequence and length are unchanged, and no further job follows it.
- R10: A depth code of 2, or a fill whose raster operation in command bits 31:24 is not 0x00, 0x5A, 0xF0 or 0xFF, sets the error flag and starts nothing. The next accepted command clears the flag.
- R11: After reset, busy and the error flag are 0 and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register word offset for writes |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register word offset for reads |
| rd_data_o | output | 32 | Read data: status at offset 0, parameter words elsewhere |
| busy_o | output | 1 | Job in progress |
| pix_valid_o | output | 1 | Destination pixel strobe |
| dst_addr_o | output | 32 | Destination byte address |
| src_valid_o | output | 1 | Source pixel strobe |
| src_addr_o | output | 32 | Source byte address |
| src_bit_o | output | 3 | Bit index within the source byte for monochrome sources |

## Verification
The bench targets the row turn. A walker that fails to reload x, or that steps y in the wrong direction after a reversed row, gives a wrong address on the first pixel of the second row. A 1x1 job and a 4096-pixel single row test the count-minus-one coding; an off-by-one there shows up as an extra or a missing strobe. A monochrome source at x = 32767 walked backwards catches a byte/bit split that truncates x or scales it by depth. Command writes during a job, together with the rejected depth and raster codes, expose designs that restart, lengthen the job, or start on bad input instead of raising the error flag.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam int DATA_W = 32;
  localparam int ADR_W  = 32;
  localparam int CRD_W  = 16;
  localparam int EXT_W  = 12;
  localparam int PIT_W  = 11;
  localparam int BAS_W  = 29;
  localparam int REG_AW = 3;
  localparam int NREG   = 1 << REG_AW;

  typedef enum logic [1:0] {
    OP_FILL  = 2'd0,
    OP_COLOR = 2'd1,
    OP_MONO  = 2'd2
  } op_e;

  typedef struct packed {
    op_e              op;
    logic             rev_x;
    logic             rev_y;
    logic [1:0]       bpp_sh;
    logic [EXT_W-1:0] wm1;
    logic [EXT_W-1:0] hm1;
    logic [CRD_W-1:0] dx0;
    logic [CRD_W-1:0] dy0;
    logic [CRD_W-1:0] sx0;
    logic [CRD_W-1:0] sy0;
    logic [BAS_W-1:0] dbase;
    logic [BAS_W-1:0] sbase;
    logic [PIT_W-1:0] dpitch;
    logic [PIT_W-1:0] spitch;
  } job_t;

  function automatic logic depth_ok(input logic [1:0] code);
    return code != 2'd2;
  endfunction

  function automatic logic [1:0] depth_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic rop_ok(input logic [7:0] rop);
    return (rop == 8'h00) || (rop == 8'h5A) || (rop == 8'hF0) || (rop == 8'hFF);
  endfunction

endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  input  logic              busy_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              start_o,
  output job_t              job_o,
  output logic              err_o
);

  localparam int POS_Y_LSB = DATA_W / 2;
  localparam logic [REG_AW-1:0] A_CMD = '0;

  logic [DATA_W-1:0] regs_q [1:NREG-1];
  logic [DATA_W-1:0] regs_d [1:NREG-1];
  logic              err_q, err_d;
  logic              cmd_hit, cmd_fill, cmd_mono, cmd_ok;
  logic [1:0]        depth_code;

  assign cmd_hit    = wr_en_i && (wr_addr_i == A_CMD);
  assign cmd_fill   = wr_data_i[13];
  assign cmd_mono   = wr_data_i[1];
  assign depth_code = regs_q[1][9:8];
  assign cmd_ok     = depth_ok(depth_code) && (!cmd_fill || rop_ok(wr_data_i[31:24]));

  always_comb begin
    for (int i = 1; i < NREG; i++) begin
      regs_d[i] = regs_q[i];
      if (wr_en_i && (wr_addr_i == REG_AW'(i))) regs_d[i] = wr_data_i;
    end
    err_d = err_q;
    if (cmd_hit && !busy_i) err_d = !cmd_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i < NREG; i++) regs_q[i] <= '0;
      err_q <= 1'b0;
    end else begin
      for (int i = 1; i < NREG; i++) regs_q[i] <= regs_d[i];
      err_q <= err_d;
    end
  end

  assign start_o = cmd_hit && !busy_i && cmd_ok;

  always_comb begin
    job_o.op     = cmd_fill ? OP_FILL : (cmd_mono ? OP_MONO : OP_COLOR);
    job_o.rev_x  = wr_data_i[15];
    job_o.rev_y  = wr_data_i[14];
    job_o.bpp_sh = depth_shift(depth_code);
    job_o.wm1    = regs_q[4][EXT_W-1:0];
    job_o.hm1    = regs_q[4][POS_Y_LSB +: EXT_W];
    job_o.dx0    = regs_q[2][CRD_W-1:0];
    job_o.dy0    = regs_q[2][POS_Y_LSB +: CRD_W];
    job_o.sx0    = regs_q[3][CRD_W-1:0];
    job_o.sy0    = regs_q[3][POS_Y_LSB +: CRD_W];
    job_o.dbase  = regs_q[5][BAS_W-1:0];
    job_o.sbase  = regs_q[6][BAS_W-1:0];
    job_o.spitch = regs_q[7][PIT_W-1:0];
    job_o.dpitch = regs_q[7][POS_Y_LSB +: PIT_W];
  end

  always_comb begin
    if (rd_addr_i == A_CMD) rd_data_o = {{(DATA_W-2){1'b0}}, err_q, busy_i};
    else                    rd_data_o = regs_q[rd_addr_i];
  end

  assign err_o = err_q;

  // R9: a command during a job leaves the error flag as it was
  p_busy_cmd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && busy_i) |=> (err_q == $past(err_q)));

  // R10: a rejected command raises the flag and the walker stays idle
  p_err_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !busy_i && !cmd_ok) |=> (err_q && !busy_i));

endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  job_t             job_i,
  output logic             busy_o,
  output job_t             job_o,
  output logic [CRD_W-1:0] dx_o,
  output logic [CRD_W-1:0] dy_o,
  output logic [CRD_W-1:0] sx_o,
  output logic [CRD_W-1:0] sy_o
);

  logic             busy_q, busy_d;
  job_t             job_q, job_d;
  logic [EXT_W-1:0] xc_q, xc_d, yc_q, yc_d;
  logic [CRD_W-1:0] dx_q, dx_d, dy_q, dy_d, sx_q, sx_d, sy_q, sy_d;
  logic             walk_en;

  function automatic logic [CRD_W-1:0] step(input logic [CRD_W-1:0] v, input logic rev);
    return rev ? (v - CRD_W'(1)) : (v + CRD_W'(1));
  endfunction

  assign walk_en = start_i || busy_q;

  always_comb begin
    busy_d = busy_q;
    job_d  = job_q;
    xc_d   = xc_q;
    yc_d   = yc_q;
    dx_d   = dx_q;
    dy_d   = dy_q;
    sx_d   = sx_q;
    sy_d   = sy_q;
    if (start_i) begin
      busy_d = 1'b1;
      job_d  = job_i;
      xc_d   = job_i.wm1;
      yc_d   = job_i.hm1;
      dx_d   = job_i.dx0;
      dy_d   = job_i.dy0;
      sx_d   = job_i.sx0;
      sy_d   = job_i.sy0;
    end else if (busy_q) begin
      if (xc_q != '0) begin
        xc_d = xc_q - EXT_W'(1);
        dx_d = step(dx_q, job_q.rev_x);
        sx_d = step(sx_q, job_q.rev_x);
      end else if (yc_q != '0) begin
        yc_d = yc_q - EXT_W'(1);
        xc_d = job_q.wm1;
        dx_d = job_q.dx0;
        sx_d = job_q.sx0;
        dy_d = step(dy_q, job_q.rev_y);
        sy_d = step(sy_q, job_q.rev_y);
      end else begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      job_q  <= '0;
      xc_q   <= '0;
      yc_q   <= '0;
      dx_q   <= '0;
      dy_q   <= '0;
      sx_q   <= '0;
      sy_q   <= '0;
    end else if (walk_en) begin
      busy_q <= busy_d;
      job_q  <= job_d;
      xc_q   <= xc_d;
      yc_q   <= yc_d;
      dx_q   <= dx_d;
      dy_q   <= dy_d;
      sx_q   <= sx_d;
      sy_q   <= sy_d;
    end
  end

  assign busy_o = busy_q;
  assign job_o  = job_q;
  assign dx_o   = dx_q;
  assign dy_o   = dy_q;
  assign sx_o   = sx_q;
  assign sy_o   = sy_q;

  // R1: the job ends right after its last pixel
  p_done_at_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (xc_q == '0) && (yc_q == '0)) |=> !busy_q);

  // R4: within a row x moves one step in the chosen direction
  p_x_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && ($past(xc_q) != '0)) |->
    (dx_q == ($past(job_q.rev_x) ? ($past(dx_q) - CRD_W'(1)) : ($past(dx_q) + CRD_W'(1)))));

  // R5: at a row turn y steps and x returns to its start
  p_y_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && ($past(xc_q) == '0)) |->
    ((dy_q == ($past(job_q.rev_y) ? ($past(dy_q) - CRD_W'(1)) : ($past(dy_q) + CRD_W'(1))))
     && (dx_q == job_q.dx0)));

endmodule

// File: rtl/blit_addr.sv
module blit_addr
  import blit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  job_t             job_i,
  input  logic [CRD_W-1:0] dx_i,
  input  logic [CRD_W-1:0] dy_i,
  input  logic [CRD_W-1:0] sx_i,
  input  logic [CRD_W-1:0] sy_i,
  output logic             pix_valid_o,
  output logic [ADR_W-1:0] dst_addr_o,
  output logic             src_valid_o,
  output logic [ADR_W-1:0] src_addr_o,
  output logic [2:0]       src_bit_o
);

  localparam int UNIT_SH = 3;

  logic [ADR_W-1:0] d_row, d_col, s_row, s_col;
  logic             is_mono;

  assign is_mono = (job_i.op == OP_MONO);

  always_comb begin
    d_row = ADR_W'(dy_i) * ADR_W'({job_i.dpitch, {UNIT_SH{1'b0}}});
    d_col = ADR_W'(dx_i) << job_i.bpp_sh;
    s_row = ADR_W'(sy_i) * ADR_W'({job_i.spitch, {UNIT_SH{1'b0}}});
    s_col = is_mono ? ADR_W'(sx_i >> UNIT_SH) : (ADR_W'(sx_i) << job_i.bpp_sh);
  end

  assign pix_valid_o = busy_i;
  assign src_valid_o = busy_i && (job_i.op != OP_FILL);
  assign dst_addr_o  = ADR_W'({job_i.dbase, {UNIT_SH{1'b0}}}) + d_row + d_col;
  assign src_addr_o  = ADR_W'({job_i.sbase, {UNIT_SH{1'b0}}}) + s_row + s_col;
  assign src_bit_o   = is_mono ? sx_i[2:0] : 3'd0;

  // R3: at 4 bytes per pixel every destination address is word aligned
  p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && (job_i.bpp_sh == 2'd2)) |-> (dst_addr_o[1:0] == 2'b00));

  // R6: a color copy steps its source in lockstep with the destination
  p_src_lockstep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && $past(pix_valid_o) && (job_i.op == OP_COLOR) && (dy_i == $past(dy_i))
     && (sy_i == $past(sy_i))) |->
    ((dst_addr_o - $past(dst_addr_o)) == (src_addr_o - $past(src_addr_o))));

endmodule

// File: rtl/rect_blit_walker.sv
module rect_blit_walker
  import blit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              pix_valid_o,
  output logic [ADR_W-1:0]  dst_addr_o,
  output logic              src_valid_o,
  output logic [ADR_W-1:0]  src_addr_o,
  output logic [2:0]        src_bit_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   start, busy, err;
  job_t                   job_new, job_run;
  logic [CRD_W-1:0]       dx, dy, sx, sy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  blit_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .busy_i    (busy),
    .rd_data_o (rd_data_o),
    .start_o   (start),
    .job_o     (job_new),
    .err_o     (err)
  );

  blit_walker u_walk (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start),
    .job_i   (job_new),
    .busy_o  (busy),
    .job_o   (job_run),
    .dx_o    (dx),
    .dy_o    (dy),
    .sx_o    (sx),
    .sy_o    (sy)
  );

  blit_addr u_addr (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .busy_i      (busy),
    .job_i       (job_run),
    .dx_i        (dx),
    .dy_i        (dy),
    .sx_i        (sx),
    .sy_i        (sy),
    .pix_valid_o (pix_valid_o),
    .dst_addr_o  (dst_addr_o),
    .src_valid_o (src_valid_o),
    .src_addr_o  (src_addr_o),
    .src_bit_o   (src_bit_o)
  );

  assign busy_o = busy;

  // R10: a job never starts while the error flag is being raised
  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(err)) |-> !$rose(busy));

endmodule

// File: tb/rect_blit_walker_tb_top.sv
module rect_blit_walker_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en_i;
  logic [2:0]  wr_addr_i;
  logic [31:0] wr_data_i;
  logic [2:0]  rd_addr_i;
  logic [31:0] rd_data_o;
  logic        busy_o, pix_valid_o, src_valid_o;
  logic [31:0] dst_addr_o, src_addr_o;
  logic [2:0]  src_bit_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  rect_blit_walker dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .pix_valid_o(pix_valid_o), .dst_addr_o(dst_addr_o),
    .src_valid_o(src_valid_o), .src_addr_o(src_addr_o), .src_bit_o(src_bit_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // job description used by the reference functions
  int          j_op;      // 0 fill, 1 color copy, 2 mono
  int          j_depth;
  int          j_rop;
  bit          j_rx, j_ry;
  int          j_w, j_h;
  int          j_dx, j_dy, j_sx, j_sy;
  logic [31:0] j_dbase, j_sbase;
  int          j_dp8, j_sp8;
  string       j_tag;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int bytes_sh(input int code);
    return (code == 0) ? 0 : ((code == 1) ? 1 : 2);
  endfunction

  function automatic logic [15:0] coord(input int start, input int k, input bit rev);
    return rev ? 16'(start - k) : 16'(start + k);
  endfunction

  function automatic logic [31:0] exp_dst(input int i, input int j);
    logic [31:0] x, y;
    x = 32'(coord(j_dx, i, j_rx));
    y = 32'(coord(j_dy, j, j_ry));
    return (j_dbase << 3) + y * 32'(j_dp8 * 8) + (x << bytes_sh(j_depth));
  endfunction

  function automatic logic [31:0] exp_src(input int i, input int j);
    logic [31:0] x, y;
    x = 32'(coord(j_sx, i, j_rx));
    y = 32'(coord(j_sy, j, j_ry));
    if (j_op == 2) return (j_sbase << 3) + y * 32'(j_sp8 * 8) + (x >> 3);
    return (j_sbase << 3) + y * 32'(j_sp8 * 8) + (x << bytes_sh(j_depth));
  endfunction

  function automatic logic [31:0] cmd_word();
    logic [31:0] c;
    c = 32'(j_rop & 8'hFF) << 24;
    if (j_rx) c[15] = 1'b1;
    if (j_ry) c[14] = 1'b1;
    if (j_op == 0) begin c[13] = 1'b1; c[0] = 1'b1; end
    else if (j_op == 2) c[1] = 1'b1;
    else c[0] = 1'b1;
    return c;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic status(output logic [31:0] s);
    rd_addr_i = 3'd0;
    #1 s = rd_data_o;
  endtask

  task automatic load_params();
    wr(3'd1, 32'(j_depth) << 8);
    wr(3'd2, (32'(j_dy & 16'hFFFF) << 16) | 32'(j_dx & 16'hFFFF));
    wr(3'd3, (32'(j_sy & 16'hFFFF) << 16) | 32'(j_sx & 16'hFFFF));
    wr(3'd4, (32'(j_h - 1) << 16) | 32'(j_w - 1));
    wr(3'd5, j_dbase);
    wr(3'd6, j_sbase);
    wr(3'd7, (32'(j_dp8) << 16) | 32'(j_sp8));
  endtask

  // run one job; inject >= 0 issues a command write at that pixel index
  task automatic run_job(input int inject);
    logic [31:0] s;
    int k;
    load_params();
    wr(3'd0, cmd_word());
    status(s);
    chk({"R8 busy at start ", j_tag}, {30'd0, s[1:0]}, 32'd1);
    k = 0;
    for (int j = 0; j < j_h; j++) begin
      for (int i = 0; i < j_w; i++) begin
        #1;
        chk({"R1 strobe ", j_tag}, {31'd0, pix_valid_o}, 32'd1);
        chk({j_tag, " dst"}, dst_addr_o, exp_dst(i, j));
        if (j_op == 0) begin
          chk({"R6 fill no source ", j_tag}, {31'd0, src_valid_o}, 32'd0);
        end else begin
          chk({"R6 source strobe ", j_tag}, {31'd0, src_valid_o}, 32'd1);
          chk({j_tag, " src"}, src_addr_o, exp_src(i, j));
          if (j_op == 2)
            chk({"R7 bit index ", j_tag}, {29'd0, src_bit_o},
                {29'd0, 3'(coord(j_sx, i, j_rx))});
        end
        @(negedge clk);
        wr_en_i = 1'b0;
        if (k == inject) begin
          wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 32'h0000_C001;
        end
        k++;
      end
    end
    wr_en_i = 1'b0;
    #1;
    chk({"R1 no extra strobe ", j_tag}, {31'd0, pix_valid_o}, 32'd0);
    status(s);
    chk({"R8 idle after job ", j_tag}, {30'd0, s[1:0]}, 32'd0);
    repeat (2) @(negedge clk);
    #1 chk({"R9 no follow-on job ", j_tag}, {31'd0, pix_valid_o}, 32'd0);
  endtask

  task automatic set_job(input int op, input int depth, input int rop, input bit rx, input bit ry,
                         input int w, input int h, input int dx, input int dy,
                         input int sx, input int sy, input string tag);
    j_op = op; j_depth = depth; j_rop = rop; j_rx = rx; j_ry = ry;
    j_w = w; j_h = h; j_dx = dx; j_dy = dy; j_sx = sx; j_sy = sy;
    j_dbase = 32'h0000_4000; j_sbase = 32'h0001_2000; j_dp8 = 100; j_sp8 = 60;
    j_tag = tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    void'($urandom(32'h5EED_0042));
    wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0; rd_addr_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    status(s);
    chk("R11 status after reset", s, 32'd0);
    chk("R11 no strobe after reset", {31'd0, pix_valid_o}, 32'd0);

    // R1 single pixel fill at 8 bpp
    set_job(0, 0, 8'hF0, 0, 0, 1, 1, 7, 3, 0, 0, "R1");
    run_job(-1);

    // R3 16 bpp fill, 3x2
    set_job(0, 1, 8'h5A, 0, 0, 3, 2, 10, 20, 0, 0, "R3");
    run_job(-1);

    // R4 R5 reversed copy at 32 bpp, 4x3
    set_job(1, 3, 8'hCC, 1, 1, 4, 3, 40, 30, 12, 9, "R4");
    run_job(-1);
    set_job(1, 0, 8'hCC, 0, 1, 2, 4, 5, 50, 6, 51, "R5");
    run_job(-1);

    // R7 mono at the 15-bit x limit walked backwards
    set_job(2, 1, 8'hCC, 1, 0, 5, 2, 300, 4, 32767, 8, "R7");
    run_job(-1);

    // R2 full-width single row
    set_job(0, 0, 8'hFF, 0, 0, 4096, 1, 0, 1, 0, 0, "R2");
    run_job(-1);

    // R9 command during a job is ignored
    set_job(1, 1, 8'hCC, 0, 0, 3, 3, 8, 8, 2, 2, "R9");
    run_job(2);

    // R10 bad depth code
    set_job(1, 2, 8'hCC, 0, 0, 2, 2, 0, 0, 0, 0, "R10");
    load_params();
    wr(3'd0, cmd_word());
    status(s);
    chk("R10 depth 2 sets error, stays idle", {30'd0, s[1:0]}, 32'd2);
    repeat (2) @(negedge clk);
    #1 chk("R10 no strobe after bad depth", {31'd0, pix_valid_o}, 32'd0);

    // R10 bad fill raster code
    set_job(0, 0, 8'h33, 0, 0, 2, 2, 0, 0, 0, 0, "R10");
    load_params();
    wr(3'd0, cmd_word());
    status(s);
    chk("R10 bad fill rop sets error", {30'd0, s[1:0]}, 32'd2);
    #1 chk("R10 no strobe after bad rop", {31'd0, pix_valid_o}, 32'd0);

    // R10 next accepted command clears the flag (checked via run_job status)
    set_job(0, 0, 8'h00, 0, 0, 2, 1, 1, 1, 0, 0, "R10 clear");
    run_job(-1);

    // random jobs
    for (int n = 0; n < 40; n++) begin
      int op, dc, w, h;
      bit rx, ry;
      op = int'($urandom_range(0, 2));
      dc = int'($urandom_range(0, 2));
      if (dc == 2) dc = 3;
      rx = 1'($urandom_range(0, 1));
      ry = 1'($urandom_range(0, 1));
      w = int'($urandom_range(1, 7));
      h = int'($urandom_range(1, 4));
      set_job(op, dc, (op == 0) ? 8'hF0 : 8'hCC, rx, ry, w, h,
              int'($urandom_range(8, 3000)), int'($urandom_range(8, 3000)),
              (op == 2) ? int'($urandom_range(8, 32000)) : int'($urandom_range(8, 3000)),
              int'($urandom_range(8, 3000)), (rx || ry) ? "R4 R5 random" : "R2 random");
      j_dbase = 32'($urandom_range(0, 1 << 20));
      j_sbase = 32'($urandom_range(0, 1 << 20));
      j_dp8 = int'($urandom_range(1, 2047));
      j_sp8 = int'($urandom_range(1, 2047));
      run_job(-1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule